// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave that looks like a 512-byte serial EEPROM to a master on a two-wire bus. SCL and SDA arrive already synchronized to the system clock. A line watcher finds clock edges and Start and Stop conditions. A state machine then decodes a control byte and a word address. It collects write data in a 16-byte page buffer and streams read data out. The only drive onto the bus is an open-drain enable: when `sda_oe` is high the pad pulls SDA low.

A write ends with Stop. At that point the buffered page is copied into the array and a modelled programming period starts. For `PROG_CYCLES` system clocks the slave acknowledges nothing, so a master finds out that the write is done by polling with control bytes. A write-protect input guards the upper 256 bytes of the array.

The state machine has these states:
- `ST_IDLE`: waiting.
- `ST_CTRL`: shifting in the control byte.
- `ST_CTRL_ACK`: acknowledging the control byte.
- `ST_ADDR`: shifting in the word address.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_WDATA`: shifting in a data byte.
- `ST_WDATA_ACK`: acknowledging a data byte.
- `ST_RDATA`: shifting a data byte out.
- `ST_RACK`: sampling the master's acknowledge.

It has these transitions:
- Start takes any state to `ST_CTRL`.
- Stop takes any state to `ST_IDLE`.
- `ST_CTRL` goes to `ST_CTRL_ACK` on a matching control byte while not busy, and otherwise to `ST_IDLE`.
- `ST_CTRL_ACK` goes to `ST_RDATA` for a read and to `ST_ADDR` for a write.
- `ST_ADDR` goes to `ST_ADDR_ACK`, which goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RACK`.
- `ST_RACK` goes back to `ST_RDATA` on a master ACK and to `ST_IDLE` on a NACK.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: An SDA fall while SCL is high (Start) moves the block, from any state, to receiving a control byte. Data buffered by an unfinished write is thrown away, and no programming period follows.
- R2: An SDA rise while SCL is high (Stop) returns the block to idle with SDA released. If a write has received at least one whole data byte, Stop stores the buffered bytes in the array and starts the programming period.
- R3: The block changes `sda_oe` only while SCL is low. Incoming bits are sampled on the SCL rise, most significant bit first.
- R4: A control byte whose bits 7:4 equal 1010 is acknowledged on the ninth clock, and any other value gets no acknowledge. In the control byte, bit 0 set means read, bit 1 is array address bit 8, and bits 3:2 have no effect.
- R5: The word address byte and every write data byte are acknowledged.
- R6: Write bytes land at consecutive offsets inside the 16-byte page, starting at address bits 3:0 and wrapping from 15 to 0. After more than 16 bytes, each new byte replaces the oldest one, and only the last 16 are stored.
- R7: For `PROG_CYCLES` clocks after a committing Stop, no byte is acknowledged, including the control byte. After that period, acknowledges resume.
- R8: A read returns the byte at the current address MSB first and then advances the address, wrapping from 0x1FF to 0x000. A random read is done as an address write followed by a repeated Start.
- R9: A master ACK after a read byte starts the next byte. A master NACK makes the slave release SDA and go idle.
- R10: With `wp_i` high at the committing Stop, writes to addresses 0x100 to 0x1FF are acknowledged but leave the array unchanged. Writes to 0x000 to 0x0FF are still stored.
- R11: After reset the block is idle, SDA is released and no programming period is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line (wired level) |
| wp_i | input | 1 | Write protect for the upper half of the array |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
Two of the block's functions can land on the same control byte: the programming-period refusal and ordinary control-byte acceptance. The bench provokes this by sending a Start and a valid control byte right after a committing Stop, while the timer is still counting, and it expects no acknowledge. After waiting longer than the period, it sends the same byte again and expects an acknowledge. A second overlap comes from overwriting in the page buffer, where a new byte and the wrap of the page offset happen on the same byte boundary. A 20-byte write that starts near the end of a page is read back in full and compared with the last-sixteen rule.

// File: rtl/twe_pkg.sv
package twe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } twe_state_t;

    // Fixed device-type nibble expected in the control byte
    localparam logic [3:0] CTRL_TAG = 4'b1010;

    // Clock pulses per byte before the acknowledge slot
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

endpackage

// File: rtl/twe_line_watch.sv
module twe_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    // SDA moving while SCL is held high marks a bus condition
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/twe_prog_timer.sv
module twe_prog_timer #(
    parameter int unsigned CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy
);

    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left <= '0;
        end else if (launch) begin
            left <= CW'(CYCLES);
        end else if (left != '0) begin
            left <= left - CW'(1);
        end
    end

    assign busy = (left != '0);

    // R7
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

endmodule

// File: rtl/twowire_eeprom_slave.sv
module twowire_eeprom_slave
    import twe_pkg::*;
#(
    parameter int unsigned MEM_BYTES   = 512,
    parameter int unsigned PAGE_BYTES  = 16,
    parameter int unsigned PROG_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);

    localparam int unsigned AW      = $clog2(MEM_BYTES);
    localparam int unsigned PW      = $clog2(PAGE_BYTES);
    localparam int unsigned WORD_AW = AW - 1;

    twe_state_t state, nxt;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic busy;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic ctl_rd, ctl_blk, mack;
    logic [AW-1:0] ptr;
    logic [PW-1:0] off;
    logic [7:0] pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvld;
    logic [7:0] mem [MEM_BYTES];

    logic byte_end, in_write, commit, ctrl_ok, protect;

    twe_line_watch u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twe_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (commit),
        .busy   (busy)
    );

    assign byte_end = scl_fall && (cnt == BITS_PER_BYTE);
    assign in_write = (state == ST_WDATA) || (state == ST_WDATA_ACK);
    assign commit   = stop_det && in_write && (|pvld);
    assign ctrl_ok  = (shreg[7:4] == CTRL_TAG) && !busy;
    assign protect  = wp_i && ptr[AW-1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_CTRL;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_CTRL:      if (byte_end) nxt = ctrl_ok ? ST_CTRL_ACK : ST_IDLE;
                ST_CTRL_ACK:  if (scl_fall) nxt = ctl_rd ? ST_RDATA : ST_ADDR;
                ST_ADDR:      if (byte_end) nxt = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (byte_end) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (byte_end) nxt = ST_RACK;
                ST_RACK:      if (scl_fall) nxt = mack ? ST_RDATA : ST_IDLE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_CTRL_ACK, ST_ADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                               sda_oe = ~tx[7];
            default:                                sda_oe = 1'b0;
        endcase
    end

    // Shift, count and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            tx      <= '0;
            ctl_rd  <= 1'b0;
            ctl_blk <= 1'b0;
            mack    <= 1'b0;
            ptr     <= '0;
            off     <= '0;
            pvld    <= '0;
        end else if (start_det || stop_det) begin
            cnt  <= '0;
            pvld <= '0;
        end else begin
            case (state)
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_i};
                        cnt   <= cnt + 4'd1;
                    end
                    if (byte_end) begin
                        cnt <= '0;
                        if (state == ST_CTRL) begin
                            ctl_rd  <= shreg[0];
                            ctl_blk <= shreg[1];
                        end
                        if (state == ST_ADDR) begin
                            ptr <= {ctl_blk, shreg[WORD_AW-1:0]};
                            off <= shreg[PW-1:0];
                        end
                        if (state == ST_WDATA) begin
                            pvld[off]     <= 1'b1;
                            off           <= off + PW'(1);
                            ptr[PW-1:0]   <= off + PW'(1);
                        end
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall && ctl_rd) begin
                        tx  <= mem[ptr];
                        ptr <= ptr + AW'(1);
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) cnt <= cnt + 4'd1;
                    if (scl_fall) begin
                        if (cnt == BITS_PER_BYTE) cnt <= '0;
                        else                      tx  <= {tx[6:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack <= ~sda_i;
                    if (scl_fall && mack) begin
                        tx  <= mem[ptr];
                        ptr <= ptr + AW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Page buffer: indexed by page offset, so overflow overwrites oldest
    always_ff @(posedge clk) begin
        if (state == ST_WDATA && byte_end) pbuf[off] <= shreg;
    end

    // Array commit on Stop
    always_ff @(posedge clk) begin
        if (commit && !protect) begin
            for (int i = 0; i < int'(PAGE_BYTES); i++) begin
                if (pvld[i]) mem[{ptr[AW-1:PW], PW'(i)}] <= pbuf[i];
            end
        end
    end

    // R7
    no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state != ST_CTRL_ACK));

    // R3
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R3
    bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= BITS_PER_BYTE);

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

endmodule

// File: tb/tb_twowire_eeprom_slave.sv
`timescale 1ns/1ps
module tb_twowire_eeprom_slave;

    localparam int Q    = 2;
    localparam int PROG = 400;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic sda_m = 1'b1;
    logic wp    = 1'b0;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    twowire_eeprom_slave #(.PROG_CYCLES(PROG)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    int    checks = 0;
    int    fails  = 0;
    int    exp_q[$];
    string tag_q[$];
    int    obs_val;
    event  obs_ev;
    bit    done = 1'b0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) check("scoreboard underflow", obs_val, -1);
            else check(tag_q.pop_front(), obs_val, exp_q.pop_front());
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; idle(Q);
        scl   = 1'b1; idle(Q);
        sda_m = 1'b0; idle(Q);
        scl   = 1'b0; idle(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(Q);
        scl   = 1'b1; idle(Q);
        sda_m = 1'b1; idle(Q);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_m = b;    idle(Q);
        scl   = 1'b1; idle(Q);
        seen  = sda_bus; idle(Q);
        scl   = 1'b0; idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input int exp_ack, input string tag);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        exp_q.push_back(exp_ack);
        tag_q.push_back(tag);
        clock_bit(1'b1, s);
        obs_val = s ? 0 : 1;
        ->obs_ev;
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic give_ack, input string tag);
        logic s;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        exp_q.push_back(int'(exp));
        tag_q.push_back(tag);
        obs_val = int'(v);
        ->obs_ev;
        clock_bit(~give_ack, s);
    endtask

    task automatic write_seq(input logic [7:0] ctrl, input logic [7:0] addr,
                             input logic [7:0] d[], input string tag);
        bus_start();
        send_byte(ctrl, 1, {tag, " control ack"});
        send_byte(addr, 1, "R5 address ack");
        foreach (d[i]) send_byte(d[i], 1, "R5 data ack");
        bus_stop();
    endtask

    task automatic read_seq(input logic [7:0] ctrl_w, input logic [7:0] addr,
                            input logic [7:0] e[], input string tag);
        bus_start();
        send_byte(ctrl_w, 1, "R4 dummy write control ack");
        send_byte(addr, 1, "R5 address ack");
        bus_start();
        send_byte(ctrl_w | 8'h01, 1, "R8 read control ack");
        foreach (e[i]) recv_byte(e[i], (i != e.size() - 1), tag);
        idle(Q);
        check("R9 SDA released after master NACK", int'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic wait_prog();
        idle(PROG + 100);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R11 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d[];
        logic [7:0] e[];

        idle(5);
        check("R11 SDA released in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        idle(5);
        check("R11 SDA released after reset", int'(sda_oe), 0);

        // Basic write, then poll during programming
        d = new[3]; d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
        write_seq(8'hA0, 8'h10, d, "R11 first");
        bus_start();
        send_byte(8'hA0, 0, "R7 no ack while programming");
        bus_stop();
        wait_prog();
        bus_start();
        send_byte(8'hA0, 1, "R7 ack after programming ends");
        bus_stop();

        e = new[3]; e[0] = 8'h11; e[1] = 8'h22; e[2] = 8'h33;
        read_seq(8'hA0, 8'h10, e, "R8 sequential read data");

        // Wrong device nibble
        bus_start();
        send_byte(8'h50, 0, "R4 foreign control byte not acked");
        bus_stop();

        // Ignored control bits 3:2, block select via bit 1
        d = new[1]; d[0] = 8'h5A;
        write_seq(8'hAE, 8'h20, d, "R4 ignored bits");
        wait_prog();
        e = new[1]; e[0] = 8'h5A;
        read_seq(8'hA2, 8'h20, e, "R4 block bit selects 0x120");

        // Overflow past 16 bytes starting at offset 12
        d = new[20];
        foreach (d[i]) d[i] = 8'h80 + 8'(i);
        write_seq(8'hA0, 8'h3C, d, "R6 overflow");
        wait_prog();
        e = new[16];
        foreach (e[i]) e[i] = 8'h84 + 8'(i);
        read_seq(8'hA0, 8'h30, e, "R6 last sixteen kept with page wrap");

        // Write protect on upper half
        d = new[1]; d[0] = 8'h77;
        write_seq(8'hA2, 8'h40, d, "R10 unprotected");
        wait_prog();
        wp = 1'b1;
        d[0] = 8'hC3;
        write_seq(8'hA2, 8'h40, d, "R10 protected write still acked");
        wait_prog();
        d[0] = 8'h3C;
        write_seq(8'hA0, 8'h40, d, "R10 lower half");
        wait_prog();
        e = new[1]; e[0] = 8'h77;
        read_seq(8'hA2, 8'h40, e, "R10 upper byte unchanged");
        e[0] = 8'h3C;
        read_seq(8'hA0, 8'h40, e, "R10 lower byte written");
        wp = 1'b0;

        // Address wrap at top of array
        d = new[1]; d[0] = 8'hEE;
        write_seq(8'hA2, 8'hFF, d, "R8 top byte");
        wait_prog();
        d[0] = 8'h01;
        write_seq(8'hA0, 8'h00, d, "R8 bottom byte");
        wait_prog();
        e = new[2]; e[0] = 8'hEE; e[1] = 8'h01;
        read_seq(8'hA2, 8'hFF, e, "R8 wrap 0x1FF to 0x000");

        // Aborted write via repeated Start
        d = new[1]; d[0] = 8'h12;
        write_seq(8'hA0, 8'h50, d, "R1 setup");
        wait_prog();
        bus_start();
        send_byte(8'hA0, 1, "R1 control ack");
        send_byte(8'h50, 1, "R5 address ack");
        send_byte(8'hAA, 1, "R5 data ack");
        bus_start();
        send_byte(8'hA0, 1, "R1 control ack after repeated start");
        send_byte(8'h50, 1, "R5 address ack");
        bus_start();
        send_byte(8'hA1, 1, "R8 read control ack");
        recv_byte(8'h12, 1'b0, "R1 aborted data not stored");
        bus_stop();
        bus_start();
        send_byte(8'hA0, 1, "R2 address-only write starts no programming");
        bus_stop();

        idle(20);
        check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule